// File: doc/BRIEF.md
# Streaming Serial Sample Transmitter

This block is the master side of a one-way serial link that streams measurement words. A single trigger pulse starts a burst. The block then drives its own serial clock, a data line and a framing select line until every word of the chosen set has left. The serial clock is the host clock divided by one of two ratios, a fast one and another exactly twice as slow. Configuration inputs choose four things: whether each word travels as one package or as several byte packages, whether an idle gap separates packages, which group of words makes up a burst, and the active level of the framing line.

At the trigger the block captures the whole parallel word array and the configuration. Input changes during a burst therefore cannot tear the data or alter the framing. The sixteen word slots have fixed roles. Slots 0 to 6 hold the waveform samples, with slot 6 the neutral channel. Slots 7 to 9 hold apparent power, slots 10 to 12 active power and slots 13 to 15 reactive power. Two build parameters remove the neutral channel or the reactive words, and the slots they cover are then sent as zero words.

Top module: `sample_burst_tx`

## Requirements
- R1: One serial clock period lasts DIV_FAST host cycles when the slow-select input is 0 and 2*DIV_FAST cycles when it is 1. The period is low for its first half and high for its second half. The clock rests high outside packages.
- R2: Set code 00 sends slots 0 to 15 in ascending order. Each word goes out most significant bit first and is sampled on the rising serial clock edge.
- R3: Set code 01 sends the seven waveform slots 0 to 6 in ascending order.
- R4: Set code 10 sends the nine power slots 7 to 15 in ascending order.
- R5: Set code 11 behaves exactly like set code 00.
- R6: A build without the neutral channel sends slot 6 as zero. A build without reactive words sends slots 13 to 15 as zero. Burst length and timing do not change.
- R7: With the gap enabled, each framed package holds 32 bits when the byte-package input is 0 and 8 bits when it is 1.
- R8: With the gap enabled, the framing line is inactive for exactly seven serial periods between packages. With the gap disabled, the framing line stays active for the whole burst.
- R9: The framing line is active high when the polarity input is 1 and active low when it is 0. Between bursts it rests at its inactive level.
- R10: Serial data changes only with a falling serial clock edge and is stable while the clock is high inside a package.
- R11: Busy rises on the host clock edge that accepts the trigger. It stays high for exactly bits*period + gaps*7*period host cycles, then falls as the last bit completes.
- R12: A trigger during a burst has no effect. Changes to the configuration or the word inputs during a burst also have no effect.
- R13: During and after reset: busy is low, the serial clock is high, data is low and the framing line is inactive with polarity 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Starts a burst when sampled high while idle |
| clk_slow_i | input | 1 | 0: fast serial clock, 1: half rate |
| byte_pkg_i | input | 1 | 0: one package per word, 1: byte packages |
| gap_en_i | input | 1 | 1: seven idle serial periods between packages |
| set_sel_i | input | 2 | Word set: 00 all, 01 waveforms, 10 powers, 11 as 00 |
| frame_pol_i | input | 1 | Framing active level |
| words_i | input | 16*WORD_W | Slot array, slot n at bits n*WORD_W upward |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| frame_o | output | 1 | Framing select |
| busy_o | output | 1 | Burst in progress |

## Verification
The hardest case to reach from the ports is a trigger that lands in the middle of a burst. It must be ignored, and the set code, gap enable and every slot value are changing on the same cycle. The stimulus waits a fixed number of cycles into a short waveform burst, then pulses the trigger while it swaps in a different configuration and new word values. It then checks that the original burst finished with its own length, timing and data, and that no second burst started afterwards. A second instance built without the neutral and reactive channels runs side by side under every configuration, so the zero padding is checked against the same input patterns.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

   localparam int unsigned SLOT_CNT       = 16;
   localparam int unsigned SLOT_IDX_W     = 4;
   localparam int unsigned NEUTRAL_SLOT   = 6;
   localparam int unsigned REACTIVE_SLOT0 = 13;
   localparam int unsigned GAP_PERIODS    = 7;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2
   } ssx_state_e;

   typedef enum logic [1:0] {
      SET_ALL   = 2'b00,
      SET_WAVE  = 2'b01,
      SET_POWER = 2'b10,
      SET_ALT   = 2'b11
   } ssx_set_e;

   typedef struct packed {
      logic       slow;
      logic       byte_pkg;
      logic       gap_en;
      logic       pol;
      logic [1:0] set;
   } ssx_cfg_t;

   // first slot of a word set
   function automatic logic [SLOT_IDX_W-1:0] set_first(input logic [1:0] s);
      return (s == SET_POWER) ? SLOT_IDX_W'(7) : '0;
   endfunction

   // number of words in a word set; the alternate code maps to the full set
   function automatic logic [SLOT_IDX_W:0] set_len(input logic [1:0] s);
      case (s)
         SET_WAVE:  return (SLOT_IDX_W+1)'(7);
         SET_POWER: return (SLOT_IDX_W+1)'(9);
         default:   return (SLOT_IDX_W+1)'(SLOT_CNT);
      endcase
   endfunction

endpackage

// File: rtl/ssx_timer.sv
module ssx_timer #(
   parameter int DIV_FAST = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic slow_i,
   output logic wrap_o,
   output logic sclk_hi_o
);
   localparam int DIV_SLOW = 2 * DIV_FAST;
   localparam int PH_W     = $clog2(DIV_SLOW);

   logic [PH_W-1:0] ph_q, ph_last, ph_half;

   assign ph_last   = slow_i ? PH_W'(DIV_SLOW - 1) : PH_W'(DIV_FAST - 1);
   assign ph_half   = slow_i ? PH_W'(DIV_FAST)     : PH_W'(DIV_FAST / 2);
   assign wrap_o    = run_i && (ph_q == ph_last);
   assign sclk_hi_o = (ph_q >= ph_half);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                ph_q <= '0;
      else if (!run_i || wrap_o)  ph_q <= '0;
      else                        ph_q <= ph_q + 1'b1;
   end

   // R1
   phase_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ph_q <= ph_last);

endmodule

// File: rtl/ssx_slots.sv
module ssx_slots import ssx_pkg::*; #(
   parameter int WORD_W       = 32,
   parameter bit HAS_NEUTRAL  = 1'b1,
   parameter bit HAS_REACTIVE = 1'b1
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       load_i,
   input  logic [SLOT_CNT*WORD_W-1:0] words_i,
   input  logic [SLOT_IDX_W-1:0]      idx_i,
   output logic [WORD_W-1:0]          word_o
);
   logic [WORD_W-1:0] bank [SLOT_CNT];

   for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
      logic [WORD_W-1:0] src, q;
      if ((g == NEUTRAL_SLOT && !HAS_NEUTRAL) ||
          (g >= REACTIVE_SLOT0 && !HAS_REACTIVE)) begin : g_zero
         logic unused_slot;
         assign unused_slot = ^words_i[g*WORD_W +: WORD_W];
         assign src = '0;
      end else begin : g_live
         assign src = words_i[g*WORD_W +: WORD_W];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     q <= '0;
         else if (load_i) q <= src;
      end
      assign bank[g] = q;
   end

   assign word_o = bank[idx_i];

endmodule

// File: rtl/ssx_fsm.sv
module ssx_fsm import ssx_pkg::*; #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       trig_i,
   input  logic                       wrap_i,
   input  logic                       byte_pkg_i,
   input  logic                       gap_en_i,
   input  logic [1:0]                 set_i,
   output ssx_state_e                 state_o,
   output logic [SLOT_IDX_W-1:0]      idx_o,
   output logic [$clog2(WORD_W)-1:0]  bit_o
);
   localparam int BIT_W = $clog2(WORD_W);
   localparam int SUB_W = $clog2(BYTE_W);
   localparam logic [2:0] GAP_LAST = 3'(GAP_PERIODS - 1);

   ssx_state_e          state_q;
   logic [BIT_W-1:0]    bit_q;
   logic [SLOT_IDX_W:0] word_q;
   logic [2:0]          gap_q;
   logic                word_end, pkg_end, last_word;

   assign word_end  = (bit_q == BIT_W'(WORD_W - 1));
   assign pkg_end   = byte_pkg_i ? (&bit_q[SUB_W-1:0]) : word_end;
   assign last_word = (word_q == (set_len(set_i) - 1'b1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         word_q  <= '0;
         gap_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (trig_i) begin
               state_q <= ST_SHIFT;
               bit_q   <= '0;
               word_q  <= '0;
            end
            ST_SHIFT: if (wrap_i) begin
               if (word_end) begin
                  bit_q  <= '0;
                  word_q <= word_q + 1'b1;
               end else begin
                  bit_q  <= bit_q + 1'b1;
               end
               if (word_end && last_word) begin
                  state_q <= ST_IDLE;
               end else if (pkg_end && gap_en_i) begin
                  state_q <= ST_GAP;
                  gap_q   <= '0;
               end
            end
            ST_GAP: if (wrap_i) begin
               if (gap_q == GAP_LAST) state_q <= ST_SHIFT;
               else                   gap_q   <= gap_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o = state_q;
   assign bit_o   = bit_q;
   assign idx_o   = set_first(set_i) + word_q[SLOT_IDX_W-1:0];

   // R12
   busy_trig_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_IDLE && trig_i && !wrap_i) |=>
         (state_q == $past(state_q) && bit_q == $past(bit_q) && word_q == $past(word_q)));

   // R8
   gap_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_GAP) |-> (gap_q <= GAP_LAST));

   // R11
   busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(state_q != ST_IDLE) |-> $past(trig_i));

endmodule

// File: rtl/sample_burst_tx.sv
module sample_burst_tx import ssx_pkg::*; #(
   parameter int WORD_W       = 32,
   parameter int BYTE_W       = 8,
   parameter int DIV_FAST     = 2,
   parameter bit HAS_NEUTRAL  = 1'b1,
   parameter bit HAS_REACTIVE = 1'b1
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       trig_i,
   input  logic                       clk_slow_i,
   input  logic                       byte_pkg_i,
   input  logic                       gap_en_i,
   input  logic [1:0]                 set_sel_i,
   input  logic                       frame_pol_i,
   input  logic [SLOT_CNT*WORD_W-1:0] words_i,
   output logic                       sclk_o,
   output logic                       sdata_o,
   output logic                       frame_o,
   output logic                       busy_o
);
   localparam int BIT_W = $clog2(WORD_W);

   if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0 || (WORD_W % BYTE_W) != 0) begin : g_bad_byte
      $error("BYTE_W must be a power of two of at least 2 that divides WORD_W");
   end
   if (DIV_FAST < 2 || (DIV_FAST % 2) != 0) begin : g_bad_div
      $error("DIV_FAST must be even and at least 2");
   end

   ssx_cfg_t              cfg_q, cfg_live;
   ssx_state_e            state;
   logic                  wrap, sclk_hi, shifting, load;
   logic [SLOT_IDX_W-1:0] idx;
   logic [BIT_W-1:0]      bit_cnt, pos;
   logic [WORD_W-1:0]     cur_word;

   assign cfg_live = '{slow: clk_slow_i, byte_pkg: byte_pkg_i, gap_en: gap_en_i,
                       pol: frame_pol_i, set: set_sel_i};

   // configuration follows the inputs while idle and freezes for a burst
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cfg_q <= '0;
      else if (state == ST_IDLE)  cfg_q <= cfg_live;
   end

   assign load = (state == ST_IDLE) && trig_i;

   ssx_timer #(.DIV_FAST(DIV_FAST)) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (busy_o),
      .slow_i    (cfg_q.slow),
      .wrap_o    (wrap),
      .sclk_hi_o (sclk_hi)
   );

   ssx_slots #(.WORD_W(WORD_W), .HAS_NEUTRAL(HAS_NEUTRAL), .HAS_REACTIVE(HAS_REACTIVE)) u_slots (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .words_i (words_i),
      .idx_i   (idx),
      .word_o  (cur_word)
   );

   ssx_fsm #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .trig_i     (trig_i),
      .wrap_i     (wrap),
      .byte_pkg_i (cfg_q.byte_pkg),
      .gap_en_i   (cfg_q.gap_en),
      .set_i      (cfg_q.set),
      .state_o    (state),
      .idx_o      (idx),
      .bit_o      (bit_cnt)
   );

   assign shifting = (state == ST_SHIFT);
   assign pos      = BIT_W'(WORD_W - 1) - bit_cnt;
   assign busy_o   = (state != ST_IDLE);
   assign sclk_o   = shifting ? sclk_hi : 1'b1;
   assign sdata_o  = shifting & cur_word[pos];
   assign frame_o  = shifting ~^ cfg_q.pol;

   // R10
   data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shifting && $past(shifting) && sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

   // R11
   busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> $past(wrap));

endmodule

// File: tb/sim_sample_burst_tx.sv
module sim_sample_burst_tx;
   localparam int WORD_W   = 32;
   localparam int SLOTS    = 16;
   localparam int DIV_FAST = 2;

   logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0, clr = 1'b0;
   logic slow = 1'b0, byt = 1'b0, gp = 1'b0, pol = 1'b0;
   logic [1:0] sel = 2'b00;
   logic [SLOTS*WORD_W-1:0] words = '0;
   logic sclk_w [2], sdat_w [2], frm_w [2], busy_w [2];

   int n_chk = 0, n_fail = 0;
   int exp_run = 0, exp_per = 0, exp_gap = 0;
   logic pol_cur = 1'b0;

   always #5 clk = ~clk;

   sample_burst_tx #(.DIV_FAST(DIV_FAST), .HAS_NEUTRAL(1'b1), .HAS_REACTIVE(1'b1)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .clk_slow_i(slow), .byte_pkg_i(byt),
      .gap_en_i(gp), .set_sel_i(sel), .frame_pol_i(pol), .words_i(words),
      .sclk_o(sclk_w[0]), .sdata_o(sdat_w[0]), .frame_o(frm_w[0]), .busy_o(busy_w[0]));

   sample_burst_tx #(.DIV_FAST(DIV_FAST), .HAS_NEUTRAL(1'b0), .HAS_REACTIVE(1'b0)) u1 (
      .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .clk_slow_i(slow), .byte_pkg_i(byt),
      .gap_en_i(gp), .set_sel_i(sel), .frame_pol_i(pol), .words_i(words),
      .sclk_o(sclk_w[1]), .sdata_o(sdat_w[1]), .frame_o(frm_w[1]), .busy_o(busy_w[1]));

   // monitor state, one set per instance
   int cyc = 0;
   int rx_n [2], bitc [2], run_bits [2], run_err [2], gap_c [2], gap_err [2];
   int pkg_seen [2], per_err [2], last_rise [2], busy_c [2], stab_err [2];
   logic [31:0] acc [2];
   logic [31:0] rx_w [2][16];
   logic pf [2], ps [2], pd [2];

   always @(negedge clk) begin
      cyc++;
      for (int k = 0; k < 2; k++) begin
         logic act;
         logic [31:0] nacc;
         act = (frm_w[k] == pol_cur);
         if (clr) begin
            rx_n[k] = 0; bitc[k] = 0; run_bits[k] = 0; run_err[k] = 0; gap_c[k] = 0;
            gap_err[k] = 0; pkg_seen[k] = 0; per_err[k] = 0; last_rise[k] = -1;
            busy_c[k] = 0; stab_err[k] = 0; acc[k] = '0;
         end else begin
            if (busy_w[k]) busy_c[k]++;
            if (act && pf[k] && sclk_w[k] && ps[k] && sdat_w[k] != pd[k]) stab_err[k]++;
            if (act && sclk_w[k] && !ps[k]) begin
               if (last_rise[k] >= 0 && (cyc - last_rise[k]) != exp_per) per_err[k]++;
               last_rise[k] = cyc;
               nacc = {acc[k][30:0], sdat_w[k]};
               acc[k] = nacc;
               bitc[k]++;
               run_bits[k]++;
               if (bitc[k] == 32) begin
                  if (rx_n[k] < 16) rx_w[k][rx_n[k]] = nacc;
                  rx_n[k]++;
                  bitc[k] = 0;
               end
            end
            if (!act && pf[k]) begin
               if (run_bits[k] != exp_run) run_err[k]++;
               run_bits[k] = 0; gap_c[k] = 0; last_rise[k] = -1; pkg_seen[k]++;
            end
            if (!act && busy_w[k]) gap_c[k]++;
            if (act && !pf[k] && pkg_seen[k] > 0 && gap_c[k] != exp_gap) gap_err[k]++;
         end
         pf[k] = act; ps[k] = sclk_w[k]; pd[k] = sdat_w[k];
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input int b, input int i);
      return (32'h9E3779B9 * (i + 1)) ^ {b[15:0], 16'hC35A} ^ (32'h01010101 << (i % 8));
   endfunction

   // slot roles per instance: u1 lacks the neutral slot 6 and reactive slots 13..15
   function automatic logic [31:0] expw(input int k, input int b, input int idx);
      if (k == 1 && (idx == 6 || idx >= 13)) return 32'h0;
      return pat(b, idx);
   endfunction

   task automatic fill_words(input int b);
      for (int i = 0; i < SLOTS; i++) words[i*WORD_W +: WORD_W] = pat(b, i);
   endtask

   task automatic check_burst(input int b, input int first, input int len,
                              input int exp_busy, input logic p, input logic [1:0] s);
      for (int k = 0; k < 2; k++) begin
         int mism;
         string rq;
         mism = 0;
         for (int j = 0; j < len && j < 16; j++)
            if (rx_w[k][j] !== expw(k, b, first + j)) mism++;
         rq = (k == 1) ? "R6" : (s == 2'b01) ? "R3" : (s == 2'b10) ? "R4" :
              (s == 2'b11) ? "R5" : "R2";
         chk(rx_n[k] == len, rq, "word count", rx_n[k], len);
         chk(mism == 0, rq, "mismatched words", mism, 0);
         chk(run_err[k] == 0, gp ? "R7" : "R8", "framed run length errors", run_err[k], 0);
         chk(gap_err[k] == 0, "R8", "gap length errors", gap_err[k], 0);
         chk(per_err[k] == 0, "R1", "serial period errors", per_err[k], 0);
         chk(stab_err[k] == 0, "R10", "data changes while clock high", stab_err[k], 0);
         chk(busy_c[k] == exp_busy, "R11", "busy cycles", busy_c[k], exp_busy);
         chk(frm_w[k] == !p, "R9", "idle frame level", frm_w[k], !p);
         chk(sclk_w[k] == 1'b1, "R1", "idle clock level", sclk_w[k], 1);
      end
   endtask

   task automatic start_burst();
      @(posedge clk); #2 clr = 1'b1;
      @(posedge clk); #2 clr = 1'b0; trig = 1'b1;
      @(posedge clk); #2 trig = 1'b0;
   endtask

   task automatic run_burst(input int c);
      int per, len, first, pkgs, eb;
      @(posedge clk); #2;
      slow = c[0]; byt = c[1]; gp = c[2]; sel = c[4:3]; pol = c[1] ^ c[4];
      pol_cur = pol;
      fill_words(c);
      per   = slow ? 2 * DIV_FAST : DIV_FAST;
      len   = (sel == 2'b01) ? 7 : (sel == 2'b10) ? 9 : 16;
      first = (sel == 2'b10) ? 7 : 0;
      pkgs  = len * (byt ? 4 : 1);
      exp_per = per;
      exp_gap = 7 * per;
      exp_run = gp ? (byt ? 8 : 32) : len * 32;
      eb = len * 32 * per + (gp ? (pkgs - 1) * 7 * per : 0);
      repeat (3) @(posedge clk);
      start_burst();
      while (busy_w[0] || busy_w[1]) @(posedge clk);
      repeat (3) @(posedge clk);
      #2 check_burst(c, first, len, eb, pol, sel);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", 190000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // R13 reset state
      repeat (4) @(posedge clk);
      #2;
      chk(busy_w[0] == 0 && sclk_w[0] == 1 && sdat_w[0] == 0 && frm_w[0] == 1,
          "R13", "outputs in reset {busy,sclk,data,frame}",
          {busy_w[0], sclk_w[0], sdat_w[0], frm_w[0]}, 4'b0101);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #2;
      chk(busy_w[1] == 0 && sclk_w[1] == 1 && sdat_w[1] == 0 && frm_w[1] == 1,
          "R13", "outputs after reset {busy,sclk,data,frame}",
          {busy_w[1], sclk_w[1], sdat_w[1], frm_w[1]}, 4'b0101);

      // sweep of every clock, package, gap and set combination
      for (int c = 0; c < 32; c++) run_burst(c);

      // R12: trigger, configuration and words change mid-burst
      begin
         int late_busy;
         @(posedge clk); #2;
         slow = 0; byt = 0; gp = 0; sel = 2'b01; pol = 0; pol_cur = 0;
         fill_words(77);
         exp_per = DIV_FAST; exp_gap = 7 * DIV_FAST; exp_run = 7 * 32;
         repeat (3) @(posedge clk);
         start_burst();
         repeat (100) @(posedge clk);
         #2 trig = 1'b1; sel = 2'b10; gp = 1'b1; byt = 1'b1; fill_words(200);
         @(posedge clk); #2 trig = 1'b0;
         while (busy_w[0] || busy_w[1]) @(posedge clk);
         late_busy = 0;
         for (int i = 0; i < 50; i++) begin
            @(posedge clk); #2;
            if (busy_w[0] || busy_w[1]) late_busy++;
         end
         chk(late_busy == 0, "R12", "busy cycles after ignored trigger", late_busy, 0);
         fill_words(77);
         sel = 2'b01;
         check_burst(77, 0, 7, 7 * 32 * DIV_FAST, 1'b0, 2'b01);
         chk(rx_n[0] == 7, "R12", "words in burst with ignored trigger", rx_n[0], 7);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule